// File: doc/BRIEF.md
# Vertical Blanking Line Mask Selector

This block holds four 16-bit per-line masks for the vertical blanking interval. Two of them govern the black-level pedestal in 525-line (NTSC) operation, one for odd fields and one for even fields. The other two enable teletext in 625-line (PAL) operation, again one per field parity. Software loads each mask one byte at a time. The line counter upstream reports the current line number, the field parity and the active standard, and pulses a line-start strobe. On each strobe the block registers two flags for the line just starting: `ped_off`, which removes the pedestal, and `ttx_en`, which opens the teletext window.

A mask bit means something different in each standard. In NTSC a set bit turns the pedestal off on its line. In PAL a set bit turns teletext on. The two standards also cover different 16-line windows: lines 10 to 25 in NTSC and lines 7 to 22 in PAL.

No part of the block is a data stream. The register write port is a plain strobe that is accepted on every cycle and never applies back-pressure. The line inputs are control pins that are sampled only when `line_start` is high.

Top module: `vbi_line_mask`

## Requirements
- R1: When `wr_en` is high, `wr_data` is stored in the byte picked by `wr_addr`. Bit 2 of the address selects the standard (0 = NTSC pedestal masks, 1 = PAL teletext masks). Bit 1 selects the field (0 = odd, 1 = even). Bit 0 selects the half (0 = mask bits 7..0, 1 = mask bits 15..8).
- R2: In NTSC (`std_pal` = 0), for lines 10 to 25, `ped_off` takes mask bit (line − 10) of the NTSC mask for the current field.
- R3: In PAL (`std_pal` = 1), for lines 7 to 22, `ttx_en` takes mask bit (line − 7) of the PAL mask for the current field.
- R4: On a line outside the window of the active standard, both `ped_off` and `ttx_en` are 0. In NTSC this leaves the pedestal on, and in PAL it leaves teletext off.
- R5: `field_even` = 0 selects the odd-field mask and `field_even` = 1 selects the even-field mask.
- R6: In PAL `ped_off` is always 0, and in NTSC `ttx_en` is always 0, whatever the other standard's masks hold.
- R7: The flags are registered. They change only in the cycle after `line_start` is sampled high, and they hold their value while `line_start` is low, even if the line, field or standard inputs change.
- R8: Reset (`rst_n` low) clears all four masks and both flags to 0.
- R9: If a write and `line_start` arrive in the same cycle, the flag update uses the mask contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| wr_en | input | 1 | Mask byte write strobe |
| wr_addr | input | 3 | Byte select: {standard, field, half} |
| wr_data | input | 8 | Byte to write |
| line_start | input | 1 | One-cycle pulse marking the start of a line |
| line_num | input | 10 | Current line number within the field |
| field_even | input | 1 | 1 = even field (2/4), 0 = odd field (1/3) |
| std_pal | input | 1 | 1 = PAL teletext mode, 0 = NTSC pedestal mode |
| ped_off | output | 1 | Pedestal off on the current line (NTSC) |
| ttx_en | output | 1 | Teletext enabled on the current line (PAL) |

## Verification
The bench sweeps lines 0 to 31 and line 1023 in both standards and both field parities, under several mask patterns. This exercises the window edges: 6, 7, 9, 10, 22, 23, 25 and 26.
- A design whose window is off by one, or that uses the wrong base line for a standard, sets a flag on a line just outside the window or drops one at a window end.
- A design that swaps the fields or the standards outputs another mask's bit. Each mask holds a distinct pattern, so this shows up.
- Moving the line, field or standard while no strobe is present catches flags that are decoded combinationally instead of registered.
- A write landing in the same cycle as a strobe catches a mask that bypasses the new value into the flags.
- A reset after nonzero masks shows whether the masks are really cleared.

// File: rtl/vbi_mask_pkg.sv
package vbi_mask_pkg;
  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } vbi_std_e;

  localparam int NUM_MASKS = 4;
  localparam int SEL_W     = 2;

  // mask index is {standard, field parity}
  function automatic logic [SEL_W-1:0] mask_sel(input logic pal, input logic even);
    return {pal, even};
  endfunction
endpackage

// File: rtl/vbi_mask_regs.sv
module vbi_mask_regs #(
  parameter int MASK_W = 16,
  parameter int BYTE_W = 8,
  localparam int BYTES  = MASK_W / BYTE_W,
  localparam int NBYTE  = vbi_mask_pkg::NUM_MASKS * BYTES,
  localparam int ADDR_W = $clog2(NBYTE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [vbi_mask_pkg::NUM_MASKS-1:0][MASK_W-1:0] masks_o
);
  logic [BYTE_W-1:0] byte_q [NBYTE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) byte_q[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < NBYTE)) begin
      byte_q[wr_addr] <= wr_data;
    end
  end

  for (genvar m = 0; m < vbi_mask_pkg::NUM_MASKS; m++) begin : g_mask
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign masks_o[m][b*BYTE_W +: BYTE_W] = byte_q[m*BYTES + b];
    end
  end

  // R1: a written byte appears in the addressed mask slice on the next cycle
  a_r1_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> byte_q[$past(wr_addr)] == $past(wr_data));

  // R8: leaving reset, every mask is clear
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (masks_o == '0));
endmodule

// File: rtl/vbi_line_window.sv
module vbi_line_window #(
  parameter int LINE_W = 10,
  parameter int MASK_W = 16,
  parameter int FIRST  = 10,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o,
  output logic              bit_o
);
  localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(FIRST);
  localparam logic [LINE_W-1:0] SPAN_L  = LINE_W'(MASK_W);

  logic [LINE_W-1:0] offset;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offset = line_i - FIRST_L;
    idx    = offset[IDX_W-1:0];
    hit_o  = (line_i >= FIRST_L) && (offset < SPAN_L);
    bit_o  = hit_o && mask_i[idx];
  end
endmodule

// File: rtl/vbi_line_mask.sv
module vbi_line_mask #(
  parameter int LINE_W     = 10,
  parameter int MASK_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int NTSC_FIRST = 10,
  parameter int PAL_FIRST  = 7,
  localparam int ADDR_W    = $clog2(vbi_mask_pkg::NUM_MASKS * (MASK_W / BYTE_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_even,
  input  logic              std_pal,
  output logic              ped_off,
  output logic              ttx_en
);
  import vbi_mask_pkg::*;

  logic [NUM_MASKS-1:0][MASK_W-1:0] masks;
  logic [1:0] win_hit;
  logic [1:0] win_bit;
  logic       ped_nxt, ttx_nxt;

  vbi_mask_regs #(.MASK_W(MASK_W), .BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .masks_o (masks)
  );

  // index 0: NTSC pedestal window, index 1: PAL teletext window
  for (genvar s = 0; s < 2; s++) begin : g_std
    localparam int BASE = (s == 0) ? NTSC_FIRST : PAL_FIRST;
    vbi_line_window #(.LINE_W(LINE_W), .MASK_W(MASK_W), .FIRST(BASE)) u_win (
      .line_i (line_num),
      .mask_i (masks[mask_sel(s[0], field_even)]),
      .hit_o  (win_hit[s]),
      .bit_o  (win_bit[s])
    );
  end

  always_comb begin
    ped_nxt = (vbi_std_e'(std_pal) == STD_NTSC) && win_bit[0];
    ttx_nxt = (vbi_std_e'(std_pal) == STD_PAL)  && win_bit[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ped_off <= 1'b0;
      ttx_en  <= 1'b0;
    end else if (line_start) begin
      ped_off <= ped_nxt;
      ttx_en  <= ttx_nxt;
    end
  end

  // R7: flags hold between line strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable({ped_off, ttx_en}));

  // R6: the inactive standard's flag stays low
  a_r6_pal_no_ped: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && std_pal) |=> !ped_off);
  a_r6_ntsc_no_ttx: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !std_pal) |=> !ttx_en);

  // R4: outside the active window both flags are low
  a_r4_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !(std_pal ? win_hit[1] : win_hit[0])) |=> (!ped_off && !ttx_en));
endmodule

// File: tb/vbi_line_mask_test.sv
module vbi_line_mask_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       line_start = 1'b0;
  logic [9:0] line_num = '0;
  logic       field_even = 1'b0;
  logic       std_pal = 1'b0;
  logic       ped_off, ttx_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] shadow [4];

  always #2.5 clk = ~clk;

  vbi_line_mask uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_start(line_start), .line_num(line_num), .field_even(field_even),
    .std_pal(std_pal), .ped_off(ped_off), .ttx_en(ttx_en)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a[2:1]][a[0]*8 +: 8] = d;
  endtask

  task automatic load(input int m, input logic [15:0] v);
    wr(3'(m*2), v[7:0]);
    wr(3'(m*2+1), v[15:8]);
  endtask

  // strobe one line, then sample at the following falling edge
  task automatic strobe(input logic pal, input logic even, input logic [9:0] ln);
    @(negedge clk);
    std_pal = pal; field_even = even; line_num = ln; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  function automatic logic exp_ped(input logic pal, input logic even, input int ln);
    if (pal || ln < 10 || ln > 25) return 1'b0;
    return shadow[{1'b0, even}][ln-10];
  endfunction

  function automatic logic exp_ttx(input logic pal, input logic even, input int ln);
    if (!pal || ln < 7 || ln > 22) return 1'b0;
    return shadow[{1'b1, even}][ln-7];
  endfunction

  task automatic sweep(input string tag);
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 2; f++)
        for (int ln = 0; ln < 33; ln++) begin
          int l = (ln == 32) ? 1023 : ln;
          strobe(s[0], f[0], 10'(l));
          // R2 R3 R4 R5 R6: window, polarity, field and standard selection
          check(tag, ped_off, exp_ped(s[0], f[0], l), $sformatf("ped std=%0d fld=%0d line=%0d", s, f, l));
          check(tag, ttx_en,  exp_ttx(s[0], f[0], l), $sformatf("ttx std=%0d fld=%0d line=%0d", s, f, l));
        end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", ped_off, 1'b0, "ped after reset");
    check("R8", ttx_en, 1'b0, "ttx after reset");
    sweep("R4/R8 zero masks");

    // distinct pattern per mask: R1 R5 R6
    load(0, 16'hA5C3); load(1, 16'h3C5A); load(2, 16'h0FF1); load(3, 16'hE817);
    sweep("R2/R3/R5/R6 mixed");
    load(0, 16'hFFFF); load(1, 16'h8001); load(2, 16'h8001); load(3, 16'hFFFF);
    sweep("R2/R3/R4 edges");
    for (int w = 0; w < 16; w += 5) begin
      load(0, 16'(1) << w); load(1, ~(16'(1) << w));
      load(2, 16'(1) << (15 - w)); load(3, ~(16'(1) << (15 - w)));
      sweep("R1/R5 walking");
    end

    // R7: outputs hold when inputs move without a strobe
    load(0, 16'h0001);
    strobe(1'b0, 1'b0, 10'd10);
    check("R7", ped_off, 1'b1, "ped set line 10");
    @(negedge clk); line_num = 10'd40; std_pal = 1'b1; field_even = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", ped_off, 1'b1, "ped held without strobe");
    check("R7", ttx_en, 1'b0, "ttx held without strobe");

    // R9: write colliding with a strobe uses the old byte
    load(0, 16'h0000);
    @(negedge clk);
    std_pal = 1'b0; field_even = 1'b0; line_num = 10'd10; line_start = 1'b1;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hFF;
    @(negedge clk);
    line_start = 1'b0; wr_en = 1'b0; shadow[0][7:0] = 8'hFF;
    check("R9", ped_off, 1'b0, "collision uses old mask");
    strobe(1'b0, 1'b0, 10'd10);
    check("R9", ped_off, 1'b1, "next strobe sees new mask");

    // R8: reset clears loaded masks
    load(0, 16'hFFFF); load(3, 16'hFFFF);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check("R8", ped_off, 1'b0, "ped cleared by reset");
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    strobe(1'b0, 1'b0, 10'd12);
    check("R8", ped_off, 1'b0, "ntsc mask cleared");
    strobe(1'b1, 1'b1, 10'd12);
    check("R8", ttx_en, 1'b0, "pal mask cleared");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule